// File: doc/BRIEF.md
# Compare-Match Watchdog Reset Unit

This unit turns one compare channel of a shared free-running timer into a watchdog. It has no down-counter of its own. Software loads a compare value, one byte per register write. Whenever the shared timer advances onto exactly that value, the channel raises a compare event. If the watchdog function is also enabled, the unit issues a one-clock internal reset pulse to the rest of the chip. It does not drive any external reset pin.

Software keeps the reset away in one of three ways. It can keep moving the compare value ahead of the timer, it can change the timer, or it can clear the watchdog enable before a match occurs. With the watchdog enable clear, the channel still works as a plain compare channel and still produces its event pulse.

A change to the compare value is made as a low-byte write followed by a high-byte write. Matching is held off from the low-byte write until the high-byte write has completed. This means a half-written value can never fire the reset.

Top module: `cmw_wdog`

## Requirements
- R1: After a synchronous reset, both outputs are low, the compare value is 0x0000, and both the compare enable and the watchdog enable are clear.
- R2: `cmp_match` is high for exactly the cycle after a cycle in which all of these hold: `timer_step` is 1, `timer_val` equals the compare value, the compare enable is set, and matching is not suppressed (see R8).
- R3: `wdog_rst` is high in the cycle after a cycle that meets R2 while the watchdog enable is also set, unless `wdog_rst` is already high in that cycle. The pulse is therefore never longer than one clock.
- R4: No match is detected while `timer_step` is 0, even when `timer_val` holds the compare value.
- R5: With the watchdog enable clear and the compare enable set, a match still pulses `cmp_match`, and `wdog_rst` stays low.
- R6: With the compare enable clear, neither output pulses, whatever the watchdog enable is.
- R7: Writes use `reg_addr`. Address 0 loads compare bits 7:0 and address 1 loads bits 15:8. Address 2 loads the control register, where data bit 0 is the compare enable and bit 1 is the watchdog enable. A write to address 3 changes nothing.
- R8: A write to address 0 suppresses matching in that same cycle. Suppression then lasts up to and including the cycle of the next write to address 1.
- R9: If software keeps rewriting the compare value ahead of a stepping timer, `wdog_rst` never rises. Once the rewrites stop, the reset fires when the timer reaches the last compare value.
- R10: The comparison covers all 16 bits. A timer value that equals the compare value only in its low byte does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control |
| reg_wdata | input | 8 | Register write data |
| timer_val | input | 16 | Current value of the shared timer |
| timer_step | input | 1 | High in a cycle where `timer_val` has just advanced |
| cmp_match | output | 1 | One-cycle compare event pulse |
| wdog_rst | output | 1 | One-cycle internal watchdog reset pulse |

## Verification
The timer is driven in several patterns, and each one separates a different fault:
- A count that steps across the compare value shows the one-cycle latency and the pulse width.
- A timer parked on the compare value with no step separates matching on an advance from matching on level equality.
- Two steps in a row on the same value show that the reset never lasts more than one clock.
- A value that matches only in the low byte exposes a truncated comparator.
- A byte-split update in which the old and the half-new values both meet the timer shows whether suppression covers the write cycle, the pending cycles and the high-byte cycle.
- A long serviced run followed by abandonment shows that servicing holds the reset off and that a missed service does fire it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    // Control register contents
    typedef struct packed {
        logic wdog_en;
        logic cmp_en;
    } wdg_ctl_t;

    localparam int CTL_CMP_BIT  = 0;
    localparam int CTL_WDOG_BIT = 1;

    // Event produced by the compare stage
    typedef struct packed {
        logic hit;
        logic arm_rst;
    } wdg_evt_t;

    function automatic wdg_ctl_t ctl_decode(input logic [1:0] bits);
        wdg_ctl_t c;
        c.cmp_en  = bits[CTL_CMP_BIT];
        c.wdog_en = bits[CTL_WDOG_BIT];
        return c;
    endfunction

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int TW = 16,
    parameter int BW = 8,
    localparam int NB = TW / BW,
    localparam int AW = $clog2(NB + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [BW-1:0] wr_data,
    output logic [TW-1:0] cmp_value,
    output wdg_ctl_t      ctl,
    output logic          blocked
);
    logic lo_pending;
    logic lo_wr_now;
    logic hi_wr_now;

    assign lo_wr_now = wr_en && (wr_addr == AW'(0));
    assign hi_wr_now = wr_en && (wr_addr == AW'(NB - 1));

    // One register per compare byte
    for (genvar k = 0; k < NB; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                cmp_value[k*BW +: BW] <= '0;
            else if (wr_en && wr_addr == AW'(k))
                cmp_value[k*BW +: BW] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (wr_en && wr_addr == AW'(NB))
            ctl <= ctl_decode(wr_data[1:0]);
    end

    // Half-written compare value tracker
    always_ff @(posedge clk) begin
        if (rst)
            lo_pending <= 1'b0;
        else if (hi_wr_now)
            lo_pending <= 1'b0;
        else if (lo_wr_now)
            lo_pending <= 1'b1;
    end

    assign blocked = lo_pending || lo_wr_now;

    AST_PEND_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
        (lo_wr_now && !hi_wr_now) |=> blocked); // R8
endmodule

// File: rtl/wdg_match.sv
module wdg_match
    import wdg_pkg::*;
#(
    parameter int TW = 16,
    parameter int BW = 8,
    localparam int NB = TW / BW
) (
    input  logic [TW-1:0] timer_val,
    input  logic          timer_step,
    input  logic [TW-1:0] cmp_value,
    input  wdg_ctl_t      ctl,
    input  logic          blocked,
    output wdg_evt_t      evt
);
    logic [NB-1:0] byte_eq;

    for (genvar k = 0; k < NB; k++) begin : g_eq
        assign byte_eq[k] = (timer_val[k*BW +: BW] == cmp_value[k*BW +: BW]);
    end

    always_comb begin
        evt.hit     = timer_step && (&byte_eq) && ctl.cmp_en && !blocked;
        evt.arm_rst = evt.hit && ctl.wdog_en;
    end
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wdg_evt_t evt,
    output logic     cmp_match,
    output logic     wdog_rst
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_match <= 1'b0;
            wdog_rst  <= 1'b0;
        end else begin
            cmp_match <= evt.hit;
            wdog_rst  <= evt.arm_rst && !wdog_rst;
        end
    end

    AST_RST_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |=> !wdog_rst); // R3
    AST_RST_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |-> cmp_match); // R3
endmodule

// File: rtl/cmw_wdog.sv
module cmw_wdog
    import wdg_pkg::*;
#(
    parameter int TW = 16,
    parameter int BW = 8,
    localparam int NB = TW / BW,
    localparam int AW = $clog2(NB + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [BW-1:0] reg_wdata,
    input  logic [TW-1:0] timer_val,
    input  logic          timer_step,
    output logic          cmp_match,
    output logic          wdog_rst
);
    logic [TW-1:0] cmp_value;
    wdg_ctl_t      ctl;
    logic          blocked;
    wdg_evt_t      evt;

    wdg_regs #(.TW(TW), .BW(BW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .cmp_value(cmp_value), .ctl(ctl), .blocked(blocked)
    );

    wdg_match #(.TW(TW), .BW(BW)) u_match (
        .timer_val(timer_val), .timer_step(timer_step), .cmp_value(cmp_value),
        .ctl(ctl), .blocked(blocked), .evt(evt)
    );

    wdg_pulse u_pulse (
        .clk(clk), .rst(rst), .evt(evt), .cmp_match(cmp_match), .wdog_rst(wdog_rst)
    );

    AST_MATCH_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
        cmp_match |-> $past(timer_step)); // R4
    AST_MATCH_VALUE: assert property (@(posedge clk) disable iff (rst)
        cmp_match |-> ($past(timer_val) == $past(cmp_value))); // R2
    AST_MATCH_UNBLOCKED: assert property (@(posedge clk) disable iff (rst)
        cmp_match |-> !$past(blocked)); // R8
    AST_RST_NEEDS_WDOG: assert property (@(posedge clk) disable iff (rst)
        wdog_rst |-> $past(ctl.wdog_en)); // R5
    AST_MATCH_NEEDS_CMP: assert property (@(posedge clk) disable iff (rst)
        cmp_match |-> $past(ctl.cmp_en)); // R6
endmodule

// File: tb/cmw_wdog_test.sv
`timescale 1ns/1ps
module cmw_wdog_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [15:0] timer_val = '0;
    logic        timer_step = 1'b0;
    logic        cmp_match;
    logic        wdog_rst;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    cmw_wdog uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .timer_val(timer_val), .timer_step(timer_step),
        .cmp_match(cmp_match), .wdog_rst(wdog_rst)
    );

    // Behavioural reference model
    logic [15:0] m_cmp;
    bit m_pend, m_cen, m_wen, e_m, e_r, m_hit;
    always @(posedge clk) begin
        if (rst) begin
            m_cmp = 0; m_pend = 0; m_cen = 0; m_wen = 0; e_m = 0; e_r = 0;
        end else begin
            m_hit = timer_step && (timer_val == m_cmp) && m_cen && !m_pend
                    && !(reg_wr && reg_addr == 2'd0);
            e_r = m_hit && m_wen && !e_r;
            e_m = m_hit;
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: begin m_cmp[7:0] = reg_wdata; m_pend = 1; end
                    2'd1: begin m_cmp[15:8] = reg_wdata; m_pend = 0; end
                    2'd2: begin m_cen = reg_wdata[0]; m_wen = reg_wdata[1]; end
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_checks++;
            if (cmp_match !== e_m) begin
                n_fail++;
                $display("FAIL R2 model cmp_match act=%0b exp=%0b t=%0t", cmp_match, e_m, $time);
            end
            n_checks++;
            if (wdog_rst !== e_r) begin
                n_fail++;
                $display("FAIL R3 model wdog_rst act=%0b exp=%0b t=%0t", wdog_rst, e_r, $time);
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // One cycle of stimulus; returns after outputs reflect it
    task automatic cyc(input bit w, input logic [1:0] a, input logic [7:0] d,
                       input logic [15:0] tv, input bit st);
        reg_wr = w; reg_addr = a; reg_wdata = d; timer_val = tv; timer_step = st;
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(0, 0, 0, timer_val, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst = 0;
        idle();
        chk("R1 cmp_match after reset", cmp_match, 0);
        chk("R1 wdog_rst after reset", wdog_rst, 0);
        // R1: compare value resets to zero, watchdog enable clear
        cyc(1, 2, 8'h01, 0, 0);
        cyc(0, 0, 0, 16'h0000, 1);
        chk("R1 compare resets to 0", cmp_match, 1);
        chk("R1 wdog enable reset clear", wdog_rst, 0);

        // R7 / R2 / R3: load 0x1234 and enable both
        cyc(1, 0, 8'h34, 16'h0100, 0);
        cyc(1, 1, 8'h12, 16'h0100, 0);
        cyc(1, 2, 8'h03, 16'h0100, 0);
        for (int t = 16'h1232; t < 16'h1234; t++) begin
            cyc(0, 0, 0, 16'(t), 1);
            chk("R2 no early match", cmp_match, 0);
        end
        cyc(0, 0, 0, 16'h1234, 1);
        chk("R2 match pulse", cmp_match, 1);
        chk("R3 reset pulse", wdog_rst, 1);
        cyc(0, 0, 0, 16'h1235, 1);
        chk("R3 reset one wide", wdog_rst, 0);
        chk("R2 match one wide", cmp_match, 0);

        // R4: parked timer does not match
        repeat (3) begin
            cyc(0, 0, 0, 16'h1234, 0);
            chk("R4 no match without step", cmp_match, 0);
        end

        // R3: two steps in a row on the same value
        cyc(0, 0, 0, 16'h1234, 1);
        chk("R3 first step resets", wdog_rst, 1);
        cyc(0, 0, 0, 16'h1234, 1);
        chk("R3 second match event", cmp_match, 1);
        chk("R3 no back-to-back reset", wdog_rst, 0);

        // R5: watchdog disabled, compare still active
        cyc(1, 2, 8'h01, 16'h0000, 0);
        cyc(0, 0, 0, 16'h1234, 1);
        chk("R5 match still fires", cmp_match, 1);
        chk("R5 no reset when disabled", wdog_rst, 0);

        // R6: compare disabled
        cyc(1, 2, 8'h02, 16'h0000, 0);
        cyc(0, 0, 0, 16'h1234, 1);
        chk("R6 no match", cmp_match, 0);
        chk("R6 no reset", wdog_rst, 0);

        // R7: address 3 ignored
        cyc(1, 2, 8'h03, 16'h0000, 0);
        cyc(1, 3, 8'hFF, 16'h0000, 0);
        cyc(0, 0, 0, 16'h1234, 1);
        chk("R7 addr3 leaves compare", cmp_match, 1);
        chk("R7 addr3 leaves control", wdog_rst, 1);

        // R10: high byte differs
        cyc(1, 0, 8'h34, 16'h0000, 0);
        cyc(1, 1, 8'h13, 16'h0000, 0);
        cyc(0, 0, 0, 16'h1234, 1);
        chk("R10 low byte only no match", cmp_match, 0);
        cyc(0, 0, 0, 16'h1334, 1);
        chk("R10 full match", cmp_match, 1);

        // R8: suppression across a split update
        cyc(1, 0, 8'h00, 16'h1334, 1);
        chk("R8 lo write cycle suppressed", cmp_match, 0);
        cyc(0, 0, 0, 16'h1300, 1);
        chk("R8 pending suppressed", cmp_match, 0);
        cyc(1, 1, 8'h13, 16'h1300, 1);
        chk("R8 hi write cycle suppressed", cmp_match, 0);
        cyc(0, 0, 0, 16'h1300, 1);
        chk("R8 match after hi write", cmp_match, 1);
        chk("R8 reset after hi write", wdog_rst, 1);

        // R9: serviced run, then abandon
        seen = 0;
        for (int t = 0; t < 600; t++) begin
            if (t % 50 == 0)      cyc(1, 0, 8'((t + 100) & 8'hFF), 16'(t), 1);
            else if (t % 50 == 1) cyc(1, 1, 8'((t + 99) >> 8), 16'(t), 1);
            else                  cyc(0, 0, 0, 16'(t), 1);
            if (wdog_rst) seen = 1;
        end
        chk("R9 serviced no reset", seen, 0);
        seen = 0;
        for (int t = 600; t < 700; t++) begin
            cyc(0, 0, 0, 16'(t), 1);
            if (wdog_rst) seen = 1;
        end
        chk("R9 abandoned fires", seen, 1);

        // R1: reset mid-operation clears state
        rst = 1;
        idle();
        rst = 0;
        cyc(0, 0, 0, 16'h0000, 1);
        chk("R1 enables cleared by reset", cmp_match, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule